// File: doc/BRIEF.md
# Packed Byte Compare Execution Unit

This block executes the packed "set less than" operation of a 32-bit SIMD extension in a single cycle. Each cycle it may accept one 32-bit instruction word. It pulls three register selectors, a sub-operation code and a pad field out of the word. It then reads two operands from a 16-entry extension register file and compares them one byte lane at a time. The compare is signed (two's complement) or unsigned, as the sub-operation code selects. Each lane yields 0x01 or 0x00, and the packed result is written into the destination register on the clock edge that accepts the instruction.

Entry 0 of the register file is a constant zero, and writes to it are dropped. Entries 1 to 15 are real 32-bit storage. An instruction with a non-zero pad field does nothing at all. A sub-operation code that is not one of the two compare codes writes nothing and raises a reserved-instruction pulse for one cycle.

A load port writes a register directly, and a combinational inspection port reads any register by index. Together they set up operands and observe results.

Top module: `packed_byte_cmp`

## Requirements
- R1: Instruction fields are: destination select in bits 9:6, first operand select in bits 13:10, second operand select in bits 17:14, sub-operation code in bits 20:18, pad in bits 25:21. Bits 31:26 and 5:0 have no effect.
- R2: Sub-operation code 6 is the signed compare. Result byte i (bits 8i+7:8i) is 0x01 when operand-1 byte i is less than operand-2 byte i as two's complement, and 0x00 otherwise.
- R3: Sub-operation code 7 is the unsigned compare. Result byte i is 0x01 when operand-1 byte i is less than operand-2 byte i as unsigned magnitude, and 0x00 otherwise.
- R4: A valid instruction with a non-zero pad field changes no register and does not raise rsvdFlag, whatever its sub-operation code.
- R5: A destination select of 0 writes no register. Register index 0 always reads as zero, on the operand path and on the inspection port.
- R6: When both operand selects are equal, including both 0, the destination receives 0x00000000.
- R7: A valid instruction with a zero pad field and a sub-operation code other than 6 or 7 writes no register. It drives rsvdFlag high for exactly the one cycle after the accepting edge.
- R8: Writeback happens on the rising edge where instValid is high. With instValid low, the instruction word has no effect. The operands are read before the write, so the destination may also be a source.
- R9: A synchronous reset clears registers 1 to 15 and rsvdFlag to zero.
- R10: When loadEn is high, loadData is written to register loadIdx on the rising edge. A loadIdx of 0 writes nothing. An accepted instruction write has priority over a load in the same cycle.
- R11: dbgData combinationally returns the contents of the register selected by dbgIdx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | Instruction word strobe |
| instWord | input | 32 | Instruction word |
| rsvdFlag | output | 1 | One-cycle reserved sub-operation pulse |
| loadEn | input | 1 | Direct register load enable |
| loadIdx | input | 4 | Direct load register index |
| loadData | input | 32 | Direct load value |
| dbgIdx | input | 4 | Inspection register index |
| dbgData | output | 32 | Inspection read data |

## Verification
Operands are loaded with lane values chosen so that the signed and unsigned compares give different answers: 0x80 against 0x7F, and 0xFF against 0x01. Equal lanes and lanes that differ by one separate strict less-than from less-or-equal. Further patterns are a zero register as a source, the same register for both operands, and the destination being one of the sources; these show whether register 0 reads as zero and whether the operands are read before the write. Words with a non-zero pad, destination 0, reserved sub-operation codes, a low strobe and noise in the unused bits each have to leave every register unchanged and the flag at its expected value.

// File: rtl/pcmp_pkg.sv
`timescale 1ns/1ps
package pcmp_pkg;
  localparam int IDX_W = 4;
  localparam int SUB_W = 3;

  localparam int DST_LSB = 6;
  localparam int SRC1_LSB = 10;
  localparam int SRC2_LSB = 14;
  localparam int SUB_LSB = 18;
  localparam int PAD_LSB = 21;
  localparam int PAD_W = 5;

  localparam logic [SUB_W-1:0] SUB_LT_SIGNED = 3'd6;
  localparam logic [SUB_W-1:0] SUB_LT_UNSIGNED = 3'd7;

  typedef struct packed {
    logic wrEn;
    logic isSigned;
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] srcA;
    logic [IDX_W-1:0] srcB;
  } pcmpStrobe_t;
endpackage

// File: rtl/pcmp_lane.sv
`timescale 1ns/1ps
module pcmp_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] laneA,
  input  logic [W-1:0] laneB,
  input  logic         isSigned,
  output logic         lessThan
);
  logic signed [W:0] extA;
  logic signed [W:0] extB;

  always_comb begin
    extA = {isSigned & laneA[W-1], laneA};
    extB = {isSigned & laneB[W-1], laneB};
    lessThan = extA < extB;
  end
endmodule

// File: rtl/pcmp_ctrl.sv
`timescale 1ns/1ps
module pcmp_ctrl
  import pcmp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instValid,
  input  logic [XLEN-1:0] instWord,
  output pcmpStrobe_t     strb,
  output logic            rsvdFlag
);
  logic [PAD_W-1:0] padField;
  logic [SUB_W-1:0] subOp;
  logic [IDX_W-1:0] dstSel;
  logic             padClean;
  logic             subKnown;
  logic             rsvdNext;
  logic             unusedBits;

  assign unusedBits = ^{instWord[XLEN-1:PAD_LSB+PAD_W], instWord[DST_LSB-1:0]};

  always_comb begin
    padField = instWord[PAD_LSB +: PAD_W];
    subOp    = instWord[SUB_LSB +: SUB_W];
    dstSel   = instWord[DST_LSB +: IDX_W];
    padClean = (padField == '0);
    subKnown = (subOp == SUB_LT_SIGNED) || (subOp == SUB_LT_UNSIGNED);

    strb.wrEn     = instValid && padClean && subKnown && (dstSel != '0);
    strb.isSigned = (subOp == SUB_LT_SIGNED);
    strb.wrIdx    = dstSel;
    strb.srcA     = instWord[SRC1_LSB +: IDX_W];
    strb.srcB     = instWord[SRC2_LSB +: IDX_W];
    rsvdNext      = instValid && padClean && !subKnown;
  end

  always_ff @(posedge clk) begin
    if (rst) rsvdFlag <= 1'b0;
    else     rsvdFlag <= rsvdNext;
  end

  assert_rsvd_cause_R7: assert property (@(posedge clk) disable iff (rst)
    rsvdFlag |-> ($past(instValid) && !$past(strb.wrEn)));

  assert_pad_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (instValid && instWord[PAD_LSB +: PAD_W] != '0) |=> !rsvdFlag);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !instValid |=> !rsvdFlag);
endmodule

// File: rtl/pcmp_dp.sv
`timescale 1ns/1ps
module pcmp_dp
  import pcmp_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  pcmpStrobe_t             strb,
  input  logic                    loadEn,
  input  logic [IDX_W-1:0]        loadIdx,
  input  logic [XLEN-1:0]         loadData,
  input  logic [IDX_W-1:0]        dbgIdx,
  output logic [XLEN-1:0]         dbgData
);
  localparam int LANES = XLEN / LANE_W;

  logic [NREG-1:1][XLEN-1:0] storage;
  logic [XLEN-1:0] opA;
  logic [XLEN-1:0] opB;
  logic [XLEN-1:0] laneRes;
  logic [XLEN-1:0] wrData;
  logic            sameSrc;

  function automatic logic [XLEN-1:0] readReg(input logic [IDX_W-1:0] idx);
    logic [XLEN-1:0] val;
    val = '0;
    for (int i = 1; i < NREG; i++) begin
      if (idx == IDX_W'(i)) val = storage[i];
    end
    return val;
  endfunction

  always_comb begin
    opA     = readReg(strb.srcA);
    opB     = readReg(strb.srcB);
    dbgData = readReg(dbgIdx);
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic laneLt;
    pcmp_lane #(.W(LANE_W)) laneCmp (
      .laneA   (opA[g*LANE_W +: LANE_W]),
      .laneB   (opB[g*LANE_W +: LANE_W]),
      .isSigned(strb.isSigned),
      .lessThan(laneLt)
    );
    assign laneRes[g*LANE_W +: LANE_W] = {{(LANE_W-1){1'b0}}, laneLt};
  end

  assign sameSrc = (strb.srcA == strb.srcB);
  assign wrData  = sameSrc ? '0 : laneRes;

  always_ff @(posedge clk) begin
    if (rst) begin
      storage <= '0;
    end else begin
      for (int i = 1; i < NREG; i++) begin
        if (strb.wrEn && strb.wrIdx == IDX_W'(i))
          storage[i] <= wrData;
        else if (loadEn && loadIdx == IDX_W'(i))
          storage[i] <= loadData;
      end
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!strb.wrEn && !(loadEn && loadIdx != '0)) |=> $stable(storage));

  assert_same_src_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (strb.wrEn && sameSrc) |-> (laneRes == '0));

  assert_no_wr_zero_R5: assert property (@(posedge clk) disable iff (rst)
    strb.wrEn |-> (strb.wrIdx != '0));

  assert_lane_bool_R2: assert property (@(posedge clk) disable iff (rst)
    strb.wrEn |-> ((laneRes & ~{LANES{{(LANE_W-1){1'b0}}, 1'b1}}) == '0));
endmodule

// File: rtl/packed_byte_cmp.sv
`timescale 1ns/1ps
module packed_byte_cmp
  import pcmp_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  parameter int LANE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instValid,
  input  logic [XLEN-1:0]  instWord,
  output logic             rsvdFlag,
  input  logic             loadEn,
  input  logic [IDX_W-1:0] loadIdx,
  input  logic [XLEN-1:0]  loadData,
  input  logic [IDX_W-1:0] dbgIdx,
  output logic [XLEN-1:0]  dbgData
);
  pcmpStrobe_t strb;

  pcmp_ctrl #(.XLEN(XLEN)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .instValid(instValid),
    .instWord (instWord),
    .strb     (strb),
    .rsvdFlag (rsvdFlag)
  );

  pcmp_dp #(.XLEN(XLEN), .NREG(NREG), .LANE_W(LANE_W)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .loadEn  (loadEn),
    .loadIdx (loadIdx),
    .loadData(loadData),
    .dbgIdx  (dbgIdx),
    .dbgData (dbgData)
  );
endmodule

// File: tb/packed_byte_cmp_tb.sv
`timescale 1ns/100ps
module packed_byte_cmp_tb_top;
  typedef struct {
    logic [15:0][31:0] regs;
    logic              flag;
    string             tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic        rsvdFlag;
  logic        loadEn = 1'b0;
  logic [3:0]  loadIdx = '0;
  logic [31:0] loadData = '0;
  logic [3:0]  dbgIdx = '0;
  logic [31:0] dbgData;

  logic [15:0][31:0] model = '0;
  item_t scoreQ[$];
  int vecCount = 0;
  int missCount = 0;
  bit benchDone = 1'b0;

  always #4 clk = ~clk;

  packed_byte_cmp dut_i (
    .clk(clk), .rst(rst), .instValid(instValid), .instWord(instWord),
    .rsvdFlag(rsvdFlag), .loadEn(loadEn), .loadIdx(loadIdx),
    .loadData(loadData), .dbgIdx(dbgIdx), .dbgData(dbgData)
  );

  function automatic logic [31:0] enc(input logic [4:0] pad, input logic [2:0] sub,
                                      input logic [3:0] c, input logic [3:0] b,
                                      input logic [3:0] a);
    return {6'h2A, pad, sub, c, b, a, 6'h15};
  endfunction

  function automatic logic [31:0] golden(input logic [31:0] x, input logic [31:0] y,
                                         input bit sgn);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 4; i++) begin
      if (sgn) r[8*i] = ($signed(x[8*i +: 8]) < $signed(y[8*i +: 8]));
      else     r[8*i] = (x[8*i +: 8] < y[8*i +: 8]);
    end
    return r;
  endfunction

  task automatic pushItem(input logic flag, input string tag);
    item_t it;
    it.regs = model;
    it.flag = flag;
    it.tag  = tag;
    scoreQ.push_back(it);
  endtask

  // drive one word, then record the post-edge state and one idle cycle after it
  task automatic issue(input logic v, input logic [31:0] w, input string tag);
    logic expFlag;
    logic [2:0] sub;
    logic [3:0] a;
    logic [31:0] res;
    @(negedge clk);
    instValid = v;
    instWord  = w;
    @(posedge clk);
    #1;
    instValid = 1'b0;
    sub = w[20:18];
    a   = w[9:6];
    expFlag = 1'b0;
    if (v && w[25:21] == 5'd0) begin
      if (sub == 3'd6 || sub == 3'd7) begin
        res = (w[13:10] == w[17:14]) ? 32'h0 :
              golden(model[w[13:10]], model[w[17:14]], sub == 3'd6);
        if (a != 4'd0) model[a] = res;
      end else begin
        expFlag = 1'b1;
      end
    end
    pushItem(expFlag, tag);
    @(posedge clk);
    #1;
    pushItem(1'b0, {tag, "/idle"});
  endtask

  task automatic loadReg(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    loadEn = 1'b1; loadIdx = idx; loadData = val;
    @(posedge clk);
    #1;
    loadEn = 1'b0;
    if (idx != 4'd0) model[idx] = val;
    pushItem(1'b0, "R10");
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    model = '0;
    pushItem(1'b0, "R9");
  endtask

  // monitor: pops expected items and compares every register and the flag
  always @(negedge clk) begin
    item_t it;
    bit bad;
    if (scoreQ.size() > 0) begin
      it = scoreQ.pop_front();
      bad = 1'b0;
      vecCount++;
      for (int i = 0; i < 16; i++) begin
        dbgIdx = 4'(i);
        #0.1;
        if (dbgData !== it.regs[i]) begin
          $display("FAIL %s (R11) reg %0d actual %h expected %h", it.tag, i, dbgData, it.regs[i]);
          bad = 1'b1;
        end
      end
      if (rsvdFlag !== it.flag) begin
        $display("FAIL %s (R7) rsvdFlag actual %b expected %b", it.tag, rsvdFlag, it.flag);
        bad = 1'b1;
      end
      if (bad) missCount++;
    end
  end

  initial begin
    #(8 * 100000);
    if (!benchDone) begin
      $display("FAIL watchdog expired actual running expected done");
      missCount++;
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    pushItem(1'b0, "R9 initial");
    // R10 operand setup, including ignored load to index 0 (R5)
    loadReg(4'd1, 32'h807F01FF);
    loadReg(4'd2, 32'h7F80FF01);
    loadReg(4'd3, 32'h05050505);
    loadReg(4'd4, 32'h05060405);
    loadReg(4'd0, 32'hDEADBEEF);
    loadReg(4'd7, 32'hCAFEF00D);
    loadReg(4'd8, 32'h12345678);
    issue(1'b1, enc(5'd0, 3'd6, 4'd2, 4'd1, 4'd5), "R2 signed mixed sign");
    issue(1'b1, enc(5'd0, 3'd7, 4'd2, 4'd1, 4'd6), "R3 unsigned mixed sign");
    issue(1'b1, enc(5'd0, 3'd6, 4'd4, 4'd3, 4'd9), "R2 equal and adjacent lanes");
    issue(1'b1, enc(5'd0, 3'd7, 4'd3, 4'd4, 4'd10), "R3 equal and adjacent lanes");
    issue(1'b1, enc(5'd0, 3'd6, 4'd1, 4'd1, 4'd7), "R6 same operand");
    issue(1'b1, enc(5'd0, 3'd7, 4'd0, 4'd0, 4'd8), "R6 both zero operands");
    issue(1'b1, enc(5'd0, 3'd6, 4'd1, 4'd0, 4'd11), "R5 zero reg source signed");
    issue(1'b1, enc(5'd0, 3'd7, 4'd0, 4'd2, 4'd12), "R5 zero reg second unsigned");
    issue(1'b1, enc(5'd3, 3'd6, 4'd2, 4'd1, 4'd4), "R4 pad nonzero");
    issue(1'b1, enc(5'd16, 3'd2, 4'd2, 4'd1, 4'd4), "R4 pad with reserved code");
    issue(1'b1, enc(5'd0, 3'd6, 4'd2, 4'd1, 4'd0), "R5 destination zero");
    issue(1'b1, enc(5'd0, 3'd3, 4'd2, 4'd1, 4'd3), "R7 reserved code 3");
    issue(1'b1, enc(5'd0, 3'd0, 4'd2, 4'd1, 4'd3), "R7 reserved code 0");
    issue(1'b0, enc(5'd0, 3'd7, 4'd2, 4'd1, 4'd3), "R8 strobe low");
    issue(1'b1, enc(5'd0, 3'd7, 4'd2, 4'd1, 4'd1), "R8 destination is source");
    issue(1'b1, {6'h3F, 5'd0, 3'd6, 4'd3, 4'd2, 4'd13, 6'h3F}, "R1 noise in unused bits");
    issue(1'b1, {6'h00, 5'd0, 3'd6, 4'd3, 4'd2, 4'd14, 6'h00}, "R1 clean unused bits");
    doReset();
    issue(1'b1, enc(5'd0, 3'd7, 4'd2, 4'd1, 4'd15), "R9 compare after reset");
    repeat (3) @(posedge clk);
    benchDone = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule